// File: doc/BRIEF.md
# Dual-Slot Instruction Dispatch Sequencer

This block accepts one fetched 32-bit instruction word at a time and walks through handing its sub-instructions to an execute unit. The two top bits of the word select the word's format. A long instruction carries a 30-bit payload. The other three formats carry two 15-bit slots: a left slot in bits 29:15 and a right slot in bits 14:0. Those slots issue left-then-right, right-then-left, or as a parallel pair. In parallel issue, a slot flagged by the decoder as a condition test becomes a guard, and the other slot runs only if the test leaves the condition flag true.

Each slot goes out as a one-cycle strobe with its payload and a slot identifier. The sequencer then waits for the execute unit to report completion, together with three feedback bits: PC changed, exception raised and the resulting condition flag. Only then does it decide whether the second slot issues or is dropped. An event pulse vector tags every issue and every guard outcome. A word-done pulse closes each word.

The controller is a single state machine with six states. IDLE accepts a word (transition IDLE->ISSUE_A on word_valid). ISSUE_A strobes the first slot and always moves to WAIT_A. WAIT_A holds until exec_done. It then goes to ISSUE_B if the second slot may run, or to FINISH if the word is complete or the second slot is dropped. ISSUE_B strobes the second slot and moves to WAIT_B. WAIT_B moves to FINISH on exec_done. FINISH pulses word_done and returns to IDLE.

Top module: `slot_dispatch_seq`

## Requirements
- R1: After reset, word_ready is 1 and issue_long, issue_left, issue_right, word_done, issue_slot and event_pulse are all 0.
- R2: A word with bits 31:30 = 11 issues exactly once, as a long instruction. issue_long pulses, issue_slot = 1 and issue_payload = bits 29:0. event_pulse bit 0 (long) is set in the issue cycle.
- R3: Bits 31:30 = 01 issue the left slot first and then the right slot. On the left issue, issue_left pulses, issue_slot = 2, issue_payload = bits 29:15 zero-extended and event_pulse bit 1 (left) is set. On the right issue, issue_right pulses, issue_slot = 3, issue_payload = bits 14:0 and event_pulse bit 2 (right) is set.
- R4: Bits 31:30 = 10 issue the right slot first and then the left slot, with the same strobes, identifiers, payloads and event bits as R3.
- R5: In formats 01 and 10, if the first slot's completion reports PC changed or an exception, the second slot is not issued and the word finishes.
- R6: In format 00 with left_is_cond = 1, the left slot issues first with event bit 5 (left cond-test). In its completion cycle, event bit 9 (cond-true) is set if exec_cond_flag = 1, and bit 10 (cond-false) otherwise. On true, the right slot issues with event bit 8 (right cond-exec); on false, nothing more issues.
- R7: In format 00 with left_is_cond = 0 and right_is_cond = 1, the right slot issues first with event bit 6 (right cond-test). Bits 9 and 10 are set as in R6. On true, the left slot issues with event bit 7 (left cond-exec).
- R8: In format 00 with neither slot a condition test, left issues with event bit 3 (left parallel) and then right issues with event bit 4 (right parallel). Right is dropped only if left's completion reports an exception; a PC change does not drop it.
- R9: Every issue strobe lasts one cycle and at most one strobe is active. No further slot issues until exec_done has been seen. word_ready stays 0 from acceptance until the word is finished, and word_valid is ignored while busy.
- R10: word_done pulses for exactly one cycle, in the cycle after the completion that ends the word. word_ready is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A new instruction word is offered |
| word_in | input | 32 | Instruction word |
| left_is_cond | input | 1 | Decoder marks the left slot as a condition test |
| right_is_cond | input | 1 | Decoder marks the right slot as a condition test |
| exec_done | input | 1 | Execute unit finished the issued slot |
| exec_pc_changed | input | 1 | The finished slot changed the PC |
| exec_exception | input | 1 | The finished slot raised an exception |
| exec_cond_flag | input | 1 | Condition flag after the finished slot |
| word_ready | output | 1 | Sequencer idle, a word may be accepted |
| issue_long | output | 1 | Long instruction issue strobe |
| issue_left | output | 1 | Left slot issue strobe |
| issue_right | output | 1 | Right slot issue strobe |
| issue_slot | output | 2 | Slot identifier: 0 none, 1 long, 2 left, 3 right |
| issue_payload | output | 30 | Payload of the issued slot |
| event_pulse | output | 11 | Per-category event pulses |
| word_done | output | 1 | Word finished |

## Verification
The assertions watch these properties on every cycle: one strobe at most, each strobe lasting one cycle, no new issue while a completion is still outstanding, nothing issued while idle, and word_done leading straight back to ready. They also check that cond-true and cond-false never coincide, and that nothing issues after a cond-false outcome or after an exception outside a guarded pair. Which slot goes first, the payload bits it carries, its event tag, and whether a PC change alone drops the second slot depend on the format and the decoder flags. Only the bench's scenarios, compared against a bench model of every format, can show these.

// File: rtl/sds_pkg.sv
package sds_pkg;

    localparam int EVT_N     = 11;
    localparam int EVT_IDX_W = $clog2(EVT_N);

    localparam logic [EVT_IDX_W-1:0] EV_LONG       = EVT_IDX_W'(0);
    localparam logic [EVT_IDX_W-1:0] EV_LEFT       = EVT_IDX_W'(1);
    localparam logic [EVT_IDX_W-1:0] EV_RIGHT      = EVT_IDX_W'(2);
    localparam logic [EVT_IDX_W-1:0] EV_LEFT_PAR   = EVT_IDX_W'(3);
    localparam logic [EVT_IDX_W-1:0] EV_RIGHT_PAR  = EVT_IDX_W'(4);
    localparam logic [EVT_IDX_W-1:0] EV_LEFT_TEST  = EVT_IDX_W'(5);
    localparam logic [EVT_IDX_W-1:0] EV_RIGHT_TEST = EVT_IDX_W'(6);
    localparam logic [EVT_IDX_W-1:0] EV_LEFT_EXEC  = EVT_IDX_W'(7);
    localparam logic [EVT_IDX_W-1:0] EV_RIGHT_EXEC = EVT_IDX_W'(8);
    localparam logic [EVT_IDX_W-1:0] EV_COND_TRUE  = EVT_IDX_W'(9);
    localparam logic [EVT_IDX_W-1:0] EV_COND_FALSE = EVT_IDX_W'(10);

    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_LONG  = 2'd1,
        SLOT_LEFT  = 2'd2,
        SLOT_RIGHT = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        KIND_LONG,
        KIND_SEQ,
        KIND_GUARD,
        KIND_PAR
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_A,
        ST_WAIT_A,
        ST_ISSUE_B,
        ST_WAIT_B,
        ST_FINISH
    } state_e;

endpackage

// File: rtl/sds_word_split.sv
module sds_word_split #(
    parameter int WORD_W = 32,
    parameter int SLOT_W = 15
) (
    input  logic [WORD_W-1:0] word,
    output logic [1:0]        fmt,
    output logic [WORD_W-3:0] long_pl,
    output logic [SLOT_W-1:0] left_pl,
    output logic [SLOT_W-1:0] right_pl
);
    localparam int BODY_W = WORD_W - 2;

    initial begin
        if (BODY_W != 2 * SLOT_W) $display("sds_word_split: body width must hold two slots");
    end

    always_comb begin
        fmt      = word[WORD_W-1:WORD_W-2];
        long_pl  = word[BODY_W-1:0];
        left_pl  = word[2*SLOT_W-1:SLOT_W];
        right_pl = word[SLOT_W-1:0];
    end
endmodule

// File: rtl/sds_order_plan.sv
module sds_order_plan
    import sds_pkg::*;
(
    input  logic [1:0]           fmt,
    input  logic                 lcond,
    input  logic                 rcond,
    output kind_e                kind,
    output slot_e                first_slot,
    output slot_e                second_slot,
    output logic [EVT_IDX_W-1:0] first_evt,
    output logic [EVT_IDX_W-1:0] second_evt
);
    always_comb begin
        kind        = KIND_LONG;
        first_slot  = SLOT_LONG;
        second_slot = SLOT_NONE;
        first_evt   = EV_LONG;
        second_evt  = EV_LONG;
        unique case (fmt)
            2'b11: begin
                kind       = KIND_LONG;
                first_slot = SLOT_LONG;
                first_evt  = EV_LONG;
            end
            2'b01: begin
                kind        = KIND_SEQ;
                first_slot  = SLOT_LEFT;
                first_evt   = EV_LEFT;
                second_slot = SLOT_RIGHT;
                second_evt  = EV_RIGHT;
            end
            2'b10: begin
                kind        = KIND_SEQ;
                first_slot  = SLOT_RIGHT;
                first_evt   = EV_RIGHT;
                second_slot = SLOT_LEFT;
                second_evt  = EV_LEFT;
            end
            2'b00: begin
                if (lcond) begin
                    kind        = KIND_GUARD;
                    first_slot  = SLOT_LEFT;
                    first_evt   = EV_LEFT_TEST;
                    second_slot = SLOT_RIGHT;
                    second_evt  = EV_RIGHT_EXEC;
                end else if (rcond) begin
                    kind        = KIND_GUARD;
                    first_slot  = SLOT_RIGHT;
                    first_evt   = EV_RIGHT_TEST;
                    second_slot = SLOT_LEFT;
                    second_evt  = EV_LEFT_EXEC;
                end else begin
                    kind        = KIND_PAR;
                    first_slot  = SLOT_LEFT;
                    first_evt   = EV_LEFT_PAR;
                    second_slot = SLOT_RIGHT;
                    second_evt  = EV_RIGHT_PAR;
                end
            end
        endcase
    end
endmodule

// File: rtl/sds_dispatch_fsm.sv
module sds_dispatch_fsm
    import sds_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  word_valid,
    input  kind_e kind,
    input  logic  exec_done,
    input  logic  exec_pc_changed,
    input  logic  exec_exception,
    input  logic  exec_cond_flag,
    output logic  accept,
    output logic  word_ready,
    output logic  issue_a,
    output logic  issue_b,
    output logic  cond_true_p,
    output logic  cond_false_p,
    output logic  word_done
);
    state_e state, state_nx;
    logic   go_second;

    // decides whether the second slot may run, from the first slot's report
    always_comb begin
        unique case (kind)
            KIND_LONG:  go_second = 1'b0;
            KIND_SEQ:   go_second = !(exec_pc_changed || exec_exception);
            KIND_GUARD: go_second = exec_cond_flag;
            KIND_PAR:   go_second = !exec_exception;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (word_valid) state_nx = ST_ISSUE_A;
            ST_ISSUE_A: state_nx = ST_WAIT_A;
            ST_WAIT_A:  if (exec_done) state_nx = go_second ? ST_ISSUE_B : ST_FINISH;
            ST_ISSUE_B: state_nx = ST_WAIT_B;
            ST_WAIT_B:  if (exec_done) state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        accept       = 1'b0;
        word_ready   = 1'b0;
        issue_a      = 1'b0;
        issue_b      = 1'b0;
        cond_true_p  = 1'b0;
        cond_false_p = 1'b0;
        word_done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                word_ready = 1'b1;
                accept     = word_valid;
            end
            ST_ISSUE_A: issue_a = 1'b1;
            ST_WAIT_A: begin
                if (exec_done && kind == KIND_GUARD) begin
                    cond_true_p  = exec_cond_flag;
                    cond_false_p = !exec_cond_flag;
                end
            end
            ST_ISSUE_B: issue_b = 1'b1;
            ST_WAIT_B:  ;
            ST_FINISH:  word_done = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/slot_dispatch_seq.sv
module slot_dispatch_seq
    import sds_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SLOT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              left_is_cond,
    input  logic              right_is_cond,
    input  logic              exec_done,
    input  logic              exec_pc_changed,
    input  logic              exec_exception,
    input  logic              exec_cond_flag,
    output logic              word_ready,
    output logic              issue_long,
    output logic              issue_left,
    output logic              issue_right,
    output logic [1:0]        issue_slot,
    output logic [WORD_W-3:0] issue_payload,
    output logic [EVT_N-1:0]  event_pulse,
    output logic              word_done
);
    localparam int PL_W = WORD_W - 2;

    logic [WORD_W-1:0]    word_q;
    logic                 lcond_q, rcond_q;
    logic                 accept, issue_a, issue_b, cond_true_p, cond_false_p;
    logic [1:0]           fmt;
    logic [PL_W-1:0]      long_pl;
    logic [SLOT_W-1:0]    left_pl, right_pl;
    kind_e                kind;
    slot_e                first_slot, second_slot, cur_slot;
    logic [EVT_IDX_W-1:0] first_evt, second_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            lcond_q <= 1'b0;
            rcond_q <= 1'b0;
        end else if (accept) begin
            word_q  <= word_in;
            lcond_q <= left_is_cond;
            rcond_q <= right_is_cond;
        end
    end

    sds_word_split #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_split (
        .word     (word_q),
        .fmt      (fmt),
        .long_pl  (long_pl),
        .left_pl  (left_pl),
        .right_pl (right_pl)
    );

    sds_order_plan u_plan (
        .fmt         (fmt),
        .lcond       (lcond_q),
        .rcond       (rcond_q),
        .kind        (kind),
        .first_slot  (first_slot),
        .second_slot (second_slot),
        .first_evt   (first_evt),
        .second_evt  (second_evt)
    );

    sds_dispatch_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .word_valid      (word_valid),
        .kind            (kind),
        .exec_done       (exec_done),
        .exec_pc_changed (exec_pc_changed),
        .exec_exception  (exec_exception),
        .exec_cond_flag  (exec_cond_flag),
        .accept          (accept),
        .word_ready      (word_ready),
        .issue_a         (issue_a),
        .issue_b         (issue_b),
        .cond_true_p     (cond_true_p),
        .cond_false_p    (cond_false_p),
        .word_done       (word_done)
    );

    always_comb begin
        if (issue_a)      cur_slot = first_slot;
        else if (issue_b) cur_slot = second_slot;
        else              cur_slot = SLOT_NONE;
    end

    always_comb begin
        issue_slot    = cur_slot;
        issue_long    = (cur_slot == SLOT_LONG);
        issue_left    = (cur_slot == SLOT_LEFT);
        issue_right   = (cur_slot == SLOT_RIGHT);
        unique case (cur_slot)
            SLOT_LONG:  issue_payload = long_pl;
            SLOT_LEFT:  issue_payload = PL_W'(left_pl);
            SLOT_RIGHT: issue_payload = PL_W'(right_pl);
            default:    issue_payload = '0;
        endcase
    end

    for (genvar g = 0; g < EVT_N; g++) begin : g_evt
        if (g == int'(EV_COND_TRUE)) begin : g_true
            assign event_pulse[g] = cond_true_p;
        end else if (g == int'(EV_COND_FALSE)) begin : g_false
            assign event_pulse[g] = cond_false_p;
        end else begin : g_issue
            assign event_pulse[g] = (issue_a && first_evt  == EVT_IDX_W'(g)) ||
                                    (issue_b && second_evt == EVT_IDX_W'(g));
        end
    end
endmodule

// File: rtl/sds_checker.sv
module sds_checker
    import sds_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             exec_done,
    input logic             exec_exception,
    input logic             word_ready,
    input logic             issue_long,
    input logic             issue_left,
    input logic             issue_right,
    input logic [EVT_N-1:0] event_pulse,
    input logic             word_done
);
    logic issue_any, pending, test_seen, false_seen, exc_seen;

    assign issue_any = issue_long | issue_left | issue_right;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            test_seen  <= 1'b0;
            false_seen <= 1'b0;
            exc_seen   <= 1'b0;
        end else begin
            if (issue_any)      pending <= 1'b1;
            else if (exec_done) pending <= 1'b0;
            if (word_done) begin
                test_seen  <= 1'b0;
                false_seen <= 1'b0;
                exc_seen   <= 1'b0;
            end else begin
                if (event_pulse[EV_LEFT_TEST] || event_pulse[EV_RIGHT_TEST]) test_seen <= 1'b1;
                if (event_pulse[EV_COND_FALSE]) false_seen <= 1'b1;
                if (exec_done && exec_exception && !test_seen) exc_seen <= 1'b1;
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_long, issue_left, issue_right})); // R9
    AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_any |=> !issue_any); // R9
    AST_NO_ISSUE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !issue_any); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (!issue_any && !word_done)); // R1
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> word_ready); // R10
    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(event_pulse[EV_COND_TRUE] && event_pulse[EV_COND_FALSE])); // R6
    AST_FALSE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        false_seen |-> !issue_any); // R6
    AST_EXCEPTION_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_seen |-> !issue_any); // R5
    AST_TAG_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_pulse[8:0]) |-> (issue_any && $onehot0(event_pulse[8:0]))); // R2
endmodule

bind slot_dispatch_seq sds_checker u_sds_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .exec_done      (exec_done),
    .exec_exception (exec_exception),
    .word_ready     (word_ready),
    .issue_long     (issue_long),
    .issue_left     (issue_left),
    .issue_right    (issue_right),
    .event_pulse    (event_pulse),
    .word_done      (word_done)
);

// File: tb/slot_dispatch_seq_test.sv
`timescale 1ns/1ps
module slot_dispatch_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic        left_is_cond = 1'b0, right_is_cond = 1'b0;
    logic        exec_done = 1'b0, exec_pc_changed = 1'b0;
    logic        exec_exception = 1'b0, exec_cond_flag = 1'b0;
    logic        word_ready, issue_long, issue_left, issue_right, word_done;
    logic [1:0]  issue_slot;
    logic [29:0] issue_payload;
    logic [10:0] event_pulse;

    int nchk = 0;
    int nfail = 0;
    bit finished_all = 0;

    slot_dispatch_seq uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .left_is_cond(left_is_cond), .right_is_cond(right_is_cond),
        .exec_done(exec_done), .exec_pc_changed(exec_pc_changed),
        .exec_exception(exec_exception), .exec_cond_flag(exec_cond_flag),
        .word_ready(word_ready), .issue_long(issue_long), .issue_left(issue_left),
        .issue_right(issue_right), .issue_slot(issue_slot),
        .issue_payload(issue_payload), .event_pulse(event_pulse), .word_done(word_done)
    );

    always #4 clk = ~clk;

    // expected sequence for the current word
    int          exp_n;
    logic [1:0]  exp_slot [2];
    logic [29:0] exp_pl   [2];
    logic [10:0] exp_ev   [2];
    logic [10:0] exp_cond;
    string       exp_tag;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [10:0] bitv(input int idx);
        return 11'(1) << idx;
    endfunction

    task automatic model(input logic [31:0] w, input logic lc, input logic rc,
                         input logic [1:0] pcv, input logic [1:0] excv, input logic [1:0] flg);
        logic [29:0] lp, rp;
        lp = {15'd0, w[29:15]};
        rp = {15'd0, w[14:0]};
        exp_cond = '0;
        case (w[31:30])
            2'b11: begin
                exp_n = 1; exp_slot[0] = 2'd1; exp_pl[0] = w[29:0]; exp_ev[0] = bitv(0);
                exp_tag = "R2";
            end
            2'b01, 2'b10: begin
                if (w[31:30] == 2'b01) begin
                    exp_slot[0] = 2'd2; exp_pl[0] = lp; exp_ev[0] = bitv(1);
                    exp_slot[1] = 2'd3; exp_pl[1] = rp; exp_ev[1] = bitv(2);
                    exp_tag = "R3";
                end else begin
                    exp_slot[0] = 2'd3; exp_pl[0] = rp; exp_ev[0] = bitv(2);
                    exp_slot[1] = 2'd2; exp_pl[1] = lp; exp_ev[1] = bitv(1);
                    exp_tag = "R4";
                end
                if (pcv[0] || excv[0]) begin exp_n = 1; exp_tag = "R5"; end
                else exp_n = 2;
            end
            default: begin
                if (lc) begin
                    exp_slot[0] = 2'd2; exp_pl[0] = lp; exp_ev[0] = bitv(5);
                    exp_slot[1] = 2'd3; exp_pl[1] = rp; exp_ev[1] = bitv(8);
                    exp_n = flg[0] ? 2 : 1;
                    exp_cond = flg[0] ? bitv(9) : bitv(10);
                    exp_tag = "R6";
                end else if (rc) begin
                    exp_slot[0] = 2'd3; exp_pl[0] = rp; exp_ev[0] = bitv(6);
                    exp_slot[1] = 2'd2; exp_pl[1] = lp; exp_ev[1] = bitv(7);
                    exp_n = flg[0] ? 2 : 1;
                    exp_cond = flg[0] ? bitv(9) : bitv(10);
                    exp_tag = "R7";
                end else begin
                    exp_slot[0] = 2'd2; exp_pl[0] = lp; exp_ev[0] = bitv(3);
                    exp_slot[1] = 2'd3; exp_pl[1] = rp; exp_ev[1] = bitv(4);
                    exp_n = excv[0] ? 1 : 2;
                    exp_tag = "R8";
                end
            end
        endcase
    endtask

    task automatic run_word(input logic [31:0] w, input logic lc, input logic rc,
                            input logic [1:0] pcv, input logic [1:0] excv,
                            input logic [1:0] flg, input int lat, input bit junk);
        int  got;
        int  cyc;
        bit  fin;
        logic [2:0] strobes;
        model(w, lc, rc, pcv, excv, flg);
        @(negedge clk);
        chk("R10", "ready before word", 32'(word_ready), 32'd1);
        word_valid = 1'b1; word_in = w; left_is_cond = lc; right_is_cond = rc;
        @(negedge clk);
        word_valid = 1'b0; word_in = $urandom; left_is_cond = $urandom; right_is_cond = $urandom;
        got = 0; cyc = 0; fin = 0;
        while (!fin && cyc < 60) begin
            if (word_done) begin
                fin = 1;
            end else if (issue_long || issue_left || issue_right) begin
                if (got < exp_n) begin
                    strobes = {exp_slot[got] == 2'd1, exp_slot[got] == 2'd2, exp_slot[got] == 2'd3};
                    chk(exp_tag, "slot id", 32'(issue_slot), 32'(exp_slot[got]));
                    chk(exp_tag, "payload", 32'(issue_payload), 32'(exp_pl[got]));
                    chk(exp_tag, "event tag", 32'(event_pulse), 32'(exp_ev[got]));
                    chk(exp_tag, "strobes", 32'({issue_long, issue_left, issue_right}), 32'(strobes));
                end else begin
                    chk(exp_tag, "extra issue", 32'(got + 1), 32'(exp_n));
                end
                for (int k = 0; k <= lat; k++) begin
                    @(negedge clk);
                    if (junk) begin word_valid = 1'b1; word_in = $urandom; end
                    chk("R9", "strobe held or early", 32'({issue_long, issue_left, issue_right}), 32'd0);
                    chk("R9", "ready while busy", 32'(word_ready), 32'd0);
                end
                word_valid = 1'b0;
                exec_done = 1'b1;
                exec_pc_changed = pcv[got]; exec_exception = excv[got]; exec_cond_flag = flg[got];
                #1;
                chk(got == 0 ? exp_tag : "R9", "completion events", 32'(event_pulse),
                    32'(got == 0 ? exp_cond : 11'd0));
                @(negedge clk);
                exec_done = 1'b0; exec_pc_changed = $urandom; exec_exception = $urandom;
                exec_cond_flag = $urandom;
                got++;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(exp_tag, "issue count", 32'(got), 32'(exp_n));
        chk("R10", "word_done seen", 32'(fin), 32'd1);
        @(negedge clk);
        chk("R10", "word_done one cycle", 32'(word_done), 32'd0);
        chk("R10", "ready after done", 32'(word_ready), 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", 32'(word_ready), 32'd1);
        chk("R1", "strobes in reset", 32'({issue_long, issue_left, issue_right, word_done}), 32'd0);
        chk("R1", "slot/events in reset", 32'({issue_slot, event_pulse}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", 32'({word_ready, issue_long, issue_left, issue_right, word_done}), 32'h10);

        // directed corner cases
        run_word(32'hC123_4567, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0); // R2 long
        run_word(32'h7FFF_0001, 0, 0, 2'b00, 2'b00, 2'b00, 1, 0); // R3 left then right
        run_word(32'h4000_7FFF, 0, 0, 2'b01, 2'b00, 2'b00, 0, 0); // R5 pc change drops
        run_word(32'h9555_2AAA, 0, 0, 2'b00, 2'b00, 2'b00, 2, 1); // R4 right then left, R9 junk
        run_word(32'hA5A5_5A5A, 0, 0, 2'b00, 2'b01, 2'b00, 0, 0); // R5 exception drops
        run_word(32'h1234_5678, 1, 0, 2'b00, 2'b00, 2'b01, 0, 0); // R6 guard true
        run_word(32'h1234_5678, 1, 1, 2'b00, 2'b00, 2'b00, 1, 0); // R6 guard false, left wins
        run_word(32'h2468_ACE0, 0, 1, 2'b00, 2'b00, 2'b01, 0, 0); // R7 right guard true
        run_word(32'h2468_ACE0, 0, 1, 2'b00, 2'b01, 2'b00, 0, 0); // R7 right guard false
        run_word(32'h0F0F_F0F0, 0, 0, 2'b01, 2'b00, 2'b00, 0, 0); // R8 pc change keeps right
        run_word(32'h0F0F_F0F0, 0, 0, 2'b00, 2'b01, 2'b00, 0, 0); // R8 exception drops right
        run_word(32'hC000_0000, 0, 0, 2'b11, 2'b11, 2'b11, 0, 1); // R2 long with feedback

        // constrained random words
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            logic [1:0]  pcv, excv, flg;
            w    = $urandom;
            pcv  = 2'(($urandom % 4 == 0) ? 2'b01 : 2'b00) | 2'($urandom % 2 << 1);
            excv = 2'(($urandom % 5 == 0) ? 2'b01 : 2'b00);
            flg  = 2'($urandom);
            run_word(w, 1'($urandom % 3 == 0), 1'($urandom % 3 == 0), pcv, excv, flg,
                     int'($urandom % 3), bit'($urandom % 2));
        end

        finished_all = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished_all) begin
            nchk++;
            nfail++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule